// File: doc/BRIEF.md
# Bidirectional Shift Register with Counted Shifting

This block keeps a WIDTH-bit word in a chain of flip-flops that share one clock. The whole word can be written in a single cycle. It can also be moved one position per cycle, either toward the most significant bit or toward the least significant bit. Each time the word moves, the serial input fills the position that was vacated. Moving toward the most significant bit doubles the value, and moving the other way halves it. A direction pin selects which neighbour feeds each stage.

Shifting does not run freely. A start command loads a shift amount into a down-counter. The counter allows exactly that many shift cycles, then stops, and the word stays frozen. A busy flag is high while shifts remain. A one-cycle done pulse marks the end of the run.

The same mechanism covers two uses:
- Parallel-to-serial: load a word, then shift it out through the serial output.
- Serial-to-parallel: start a run of WIDTH shifts while the serial input carries the bits. The assembled word is ready when done pulses.

Top module: `bidir_shift_seq`

## Requirements
- R1: While reset is held and after it is released, `word_q` is all zeros, `busy` is 0 and `done` is 0.
- R2: When `load_en` is 1 at a clock edge, `word_q` becomes `load_word` at that edge. This overrides any pending shift, and that cycle does not consume a count.
- R3: A shift with `dir_left` = 1 makes `word_q` equal `{word_q[WIDTH-2:0], ser_in}`. With `ser_in` = 0 this doubles the value modulo 2^WIDTH.
- R4: A shift with `dir_left` = 0 makes `word_q` equal `{ser_in, word_q[WIDTH-1:1]}`. With `ser_in` = 0 this halves the value.
- R5: `start` sampled while `busy` is 0 loads `amount`. `busy` is 1 from the next cycle until exactly `amount` shift cycles have occurred, one per non-load cycle.
- R6: `done` is high for exactly one cycle, in the cycle after the edge that performs the last shift of a run. A start with `amount` = 0 performs no shift, leaves `busy` low, and pulses `done` in the following cycle.
- R7: `start` sampled while `busy` is 1 is ignored. The remaining count is unchanged.
- R8: `ser_out` equals `word_q[WIDTH-1]` when `dir_left` = 1 and `word_q[0]` when `dir_left` = 0.
- R9: With `busy` = 0 and `load_en` = 0, `word_q` keeps its value whatever `ser_in` and `dir_left` do.
- R10: A run of `amount` = WIDTH with `dir_left` = 1 captures WIDTH serial bits, first bit ending in the MSB. The word then stays held after `done`.
- R11: A single 1 loaded into bit 0 moves up one position per shift cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Parallel write of `load_word` |
| load_word | input | WIDTH | Parallel input word |
| dir_left | input | 1 | 1: toward MSB, 0: toward LSB |
| ser_in | input | 1 | Bit entering the vacated end |
| start | input | 1 | Begin a counted run when idle |
| amount | input | AMT_W | Number of shifts for the run |
| word_q | output | WIDTH | Parallel output word |
| ser_out | output | 1 | Bit at the leaving end |
| busy | output | 1 | Shifts remain |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
Each registered result is compared one clock after the edge that samples its stimulus:
- `word_q`, `busy` and `done` all settle one edge after the edge that samples the inputs.
- `ser_out` is combinational from the current word and `dir_left`, so it is checked in the same cycle.

The bench drives inputs on the falling edge and advances its reference model on the rising edge. It compares every output on the next falling edge, so each expectation is sampled exactly one register stage after its cause. A run of n shifts is checked over n+1 cycles after `start`, with `done` expected in the last of them.

// File: rtl/bshift_pkg.sv
package bshift_pkg;

   typedef enum logic [1:0] {
      OP_HOLD  = 2'd0,
      OP_LOAD  = 2'd1,
      OP_SHIFT = 2'd2
   } bshift_op_e;

   function automatic int unsigned amt_width(input int unsigned w);
      return $clog2(w + 1);
   endfunction

endpackage

// File: rtl/bshift_stages.sv
module bshift_stages
   import bshift_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  bshift_op_e       op,
   input  logic             dir_left,
   input  logic             ser_in,
   input  logic [WIDTH-1:0] load_word,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] from_low;
   logic [WIDTH-1:0] from_high;

   for (genvar i = 0; i < WIDTH; i++) begin : g_stage
      if (i == 0) begin : g_low_end
         assign from_low[i] = ser_in;
      end else begin : g_low_mid
         assign from_low[i] = q[i-1];
      end
      if (i == WIDTH - 1) begin : g_high_end
         assign from_high[i] = ser_in;
      end else begin : g_high_mid
         assign from_high[i] = q[i+1];
      end

      logic d_next;
      always_comb begin
         unique case (op)
            OP_LOAD:  d_next = load_word[i];
            OP_SHIFT: d_next = dir_left ? from_low[i] : from_high[i];
            default:  d_next = q[i];
         endcase
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q[i] <= 1'b0;
         else        q[i] <= d_next;
      end
   end

endmodule

// File: rtl/bshift_sequencer.sv
module bshift_sequencer
   import bshift_pkg::*;
#(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned AMT_W = amt_width(WIDTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_en,
   input  logic             start,
   input  logic [AMT_W-1:0] amount,
   output bshift_op_e       op,
   output logic             busy,
   output logic             done
);

   localparam logic [AMT_W-1:0] ONE = AMT_W'(1);

   logic [AMT_W-1:0] remain;
   logic             last_shift;
   logic             empty_run;

   assign busy       = (remain != '0);
   assign last_shift = busy && !load_en && (remain == ONE);
   assign empty_run  = !busy && start && (amount == '0);

   always_comb begin
      if (load_en)   op = OP_LOAD;
      else if (busy) op = OP_SHIFT;
      else           op = OP_HOLD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain <= '0;
         done   <= 1'b0;
      end else begin
         if (busy) begin
            if (op == OP_SHIFT) remain <= remain - ONE;
         end else if (start) begin
            remain <= amount;
         end
         done <= last_shift || empty_run;
      end
   end

endmodule

// File: rtl/bshift_tap.sv
module bshift_tap #(
   parameter int unsigned WIDTH = 8
) (
   input  logic [WIDTH-1:0] q,
   input  logic             dir_left,
   output logic             ser_out
);

   assign ser_out = dir_left ? q[WIDTH-1] : q[0];

endmodule

// File: rtl/bidir_shift_seq.sv
module bidir_shift_seq
   import bshift_pkg::*;
#(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned AMT_W = amt_width(WIDTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_en,
   input  logic [WIDTH-1:0] load_word,
   input  logic             dir_left,
   input  logic             ser_in,
   input  logic             start,
   input  logic [AMT_W-1:0] amount,
   output logic [WIDTH-1:0] word_q,
   output logic             ser_out,
   output logic             busy,
   output logic             done
);

   if (WIDTH < 2) begin : g_bad_width
      $error("bidir_shift_seq: WIDTH must be at least 2");
   end
   if (AMT_W < amt_width(WIDTH)) begin : g_bad_amt
      $error("bidir_shift_seq: AMT_W too narrow to count WIDTH shifts");
   end

   bshift_op_e op;

   bshift_sequencer #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_en (load_en),
      .start   (start),
      .amount  (amount),
      .op      (op),
      .busy    (busy),
      .done    (done)
   );

   bshift_stages #(.WIDTH(WIDTH)) u_stages (
      .clk       (clk),
      .rst_n     (rst_n),
      .op        (op),
      .dir_left  (dir_left),
      .ser_in    (ser_in),
      .load_word (load_word),
      .q         (word_q)
   );

   bshift_tap #(.WIDTH(WIDTH)) u_tap (
      .q        (word_q),
      .dir_left (dir_left),
      .ser_out  (ser_out)
   );

endmodule

// File: rtl/bshift_checker.sv
module bshift_checker #(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned AMT_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             load_en,
   input logic [WIDTH-1:0] load_word,
   input logic             dir_left,
   input logic             ser_in,
   input logic             start,
   input logic [AMT_W-1:0] amount,
   input logic [WIDTH-1:0] word_q,
   input logic             busy,
   input logic             done
);

   AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |=> word_q == $past(load_word)); // R2

   AST_SHIFT_UP: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !load_en && dir_left |=>
         word_q == {$past(word_q[WIDTH-2:0]), $past(ser_in)}); // R3

   AST_SHIFT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !load_en && !dir_left |=>
         word_q == {$past(ser_in), $past(word_q[WIDTH-1:1])}); // R4

   AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start)); // R5

   AST_END_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done); // R6

   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R6

   AST_ZERO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && start && amount == '0 |=> done && !busy); // R6

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && !load_en |=> $stable(word_q)); // R9

endmodule

bind bidir_shift_seq bshift_checker #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .load_en   (load_en),
   .load_word (load_word),
   .dir_left  (dir_left),
   .ser_in    (ser_in),
   .start     (start),
   .amount    (amount),
   .word_q    (word_q),
   .busy      (busy),
   .done      (done)
);

// File: tb/sim_bidir_shift_seq.sv
`timescale 1ns/1ps
module sim_bidir_shift_seq;

   localparam int W = 8;
   localparam int A = $clog2(W + 1);

   logic         clk = 1'b0;
   logic         rst_n;
   logic         load_en;
   logic [W-1:0] load_word;
   logic         dir_left;
   logic         ser_in;
   logic         start;
   logic [A-1:0] amount;
   logic [W-1:0] word_q;
   logic         ser_out;
   logic         busy;
   logic         done;

   int n_chk  = 0;
   int n_fail = 0;
   bit ended  = 0;

   logic [W-1:0] m_word = '0;
   logic [A-1:0] m_cnt  = '0;
   logic         m_done = 1'b0;

   always #2.5 clk = ~clk;

   bidir_shift_seq #(.WIDTH(W), .AMT_W(A)) u0 (
      .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_word(load_word),
      .dir_left(dir_left), .ser_in(ser_in), .start(start), .amount(amount),
      .word_q(word_q), .ser_out(ser_out), .busy(busy), .done(done)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [W-1:0] shifted(input logic [W-1:0] w,
                                            input logic dl, input logic si);
      return dl ? {w[W-2:0], si} : {si, w[W-1:1]};
   endfunction

   task automatic compare(input string tag);
      chk(word_q === m_word, tag, "word_q", 32'(word_q), 32'(m_word));
      chk(busy === (m_cnt != 0), tag, "busy", 32'(busy), 32'(m_cnt != 0));
      chk(done === m_done, tag, "done", 32'(done), 32'(m_done));
      chk(ser_out === (dir_left ? m_word[W-1] : m_word[0]), "R8", "ser_out",
          32'(ser_out), 32'(dir_left ? m_word[W-1] : m_word[0]));
   endtask

   // Called at a falling edge: drive, model the rising edge, compare at the next falling edge.
   task automatic cycle(input logic ld, input logic [W-1:0] lw, input logic dl,
                        input logic si, input logic st, input logic [A-1:0] amt,
                        input string tag);
      logic [A-1:0] c0;
      load_en = ld; load_word = lw; dir_left = dl; ser_in = si;
      start = st; amount = amt;
      @(posedge clk);
      c0     = m_cnt;
      m_done = 1'b0;
      if (ld) m_word = lw;
      else if (c0 != 0) begin
         m_word = shifted(m_word, dl, si);
         m_cnt  = c0 - 1'b1;
         if (m_cnt == 0) m_done = 1'b1;
      end
      if (st && c0 == 0) begin
         m_cnt = amt;
         if (amt == 0) m_done = 1'b1;
      end
      @(negedge clk);
      compare(tag);
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual expired expected finished");
      finish_run();
   end

   logic [W-1:0] pat;

   initial begin : stim
      void'($urandom(32'd20240611));
      rst_n = 1'b0; load_en = 0; load_word = '0; dir_left = 0; ser_in = 0;
      start = 0; amount = '0;
      repeat (3) @(negedge clk);
      compare("R1");
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1");

      // R11: single one walking upward
      cycle(1, 8'h01, 1, 0, 0, 0, "R2");
      cycle(0, 0, 1, 0, 1, 3, "R5");
      for (int k = 0; k < 3; k++) cycle(0, 0, 1, 0, 0, 0, "R11");
      chk(word_q === 8'h08, "R11", "walk", 32'(word_q), 32'h08);
      chk(done === 1'b1, "R6", "done at end", 32'(done), 1);
      cycle(0, 0, 1, 1, 0, 0, "R9");
      chk(done === 1'b0, "R6", "done one cycle", 32'(done), 0);
      chk(word_q === 8'h08, "R9", "held", 32'(word_q), 32'h08);

      // R4: halving
      cycle(1, 8'h80, 0, 0, 1, 2, "R2");
      cycle(0, 0, 0, 0, 0, 0, "R4");
      cycle(0, 0, 0, 0, 0, 0, "R4");
      chk(word_q === 8'h20, "R4", "halve twice", 32'(word_q), 32'h20);

      // R3: doubling
      cycle(1, 8'h05, 1, 0, 1, 1, "R2");
      cycle(0, 0, 1, 0, 0, 0, "R3");
      chk(word_q === 8'h0A, "R3", "double", 32'(word_q), 32'h0A);

      // R6: zero amount
      cycle(0, 0, 1, 1, 1, 0, "R6");
      chk(busy === 1'b0 && done === 1'b1, "R6", "zero run", 32'({busy, done}), 32'b01);
      chk(word_q === 8'h0A, "R6", "no shift", 32'(word_q), 32'h0A);

      // R7: start while busy, R2: load mid-run keeps count
      cycle(0, 0, 1, 0, 1, 3, "R5");
      cycle(0, 0, 1, 0, 1, 7, "R7");
      cycle(1, 8'h11, 1, 0, 1, 7, "R2");
      cycle(0, 0, 1, 0, 0, 0, "R7");
      cycle(0, 0, 1, 0, 0, 0, "R7");
      chk(word_q === 8'h44 && done === 1'b1, "R7", "count kept",
          32'({done, word_q}), 32'h144);

      // R10: serial capture, first bit to MSB
      pat = 8'hB6;
      cycle(1, 8'h00, 1, 0, 1, A'(W), "R10");
      for (int k = 0; k < W; k++) cycle(0, 0, 1, pat[W-1-k], 0, 0, "R10");
      chk(word_q === pat, "R10", "capture", 32'(word_q), 32'(pat));
      for (int k = 0; k < 4; k++) cycle(0, 0, k[0], ~k[0], 0, 0, "R9");
      chk(word_q === pat, "R10", "capture held", 32'(word_q), 32'(pat));

      // random mix
      for (int k = 0; k < 2000; k++) begin
         cycle(($urandom % 8) == 0, W'($urandom), 1'($urandom), 1'($urandom),
               ($urandom % 4) == 0, A'($urandom % (W + 2)), "R5");
      end

      finish_run();
   end

endmodule